// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip request stream and an external asynchronous static RAM. Each request asks for one word, either a read or a write. The controller turns it into a sequence of chip-enable, output-enable and write-enable strobes, all active low, together with a held address and a data bus that is split into output, output-enable and input. The tristate pad itself belongs to the pad ring. Every strobe stays low for a whole number of clock cycles. These counts are derived at elaboration from the RAM's minimum timing figures and the clock period, always rounding up, so the same RTL serves any clock rate and either speed grade.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the controller is idle. A request that arrives while the controller is busy simply waits: the requester must hold `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. The request fields are captured at that edge, so they may change freely afterwards. The read response has no back-pressure. It is a single-cycle `rd_valid` pulse carrying the captured word, and the receiver must accept it in that cycle.

Writes keep output-enable high throughout, and each write ends when write-enable and chip-enable rise together. The controller's data drive is tied to the write cycle. Reads are always followed by a turnaround gap in which the controller does not drive, so that the RAM's outputs have released the bus before the controller drives it again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: `req_ready` is 1 exactly when no access is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_write`, `req_addr` and `req_wdata` are captured at that edge, and later changes to them do not affect the access.
- R3: A read puts out one SETUP cycle (CE=0, OE=1, WE=1) and then RD_CYC cycles with CE=0 and OE=0. WE stays 1 and `mem_dq_oe` stays 0 throughout.
- R4: The RAM data is sampled at the clock edge that ends the last OE-low cycle. `rd_valid` is 1 for exactly the following cycle, and `rd_data` holds the sampled word.
- R5: A write puts out one SETUP cycle (CE=0, OE=1, WE=1, data driven), then WR_CYC cycles with CE=0 and WE=0, then one HOLD cycle with all strobes 1. Data is driven with the accepted word from SETUP through HOLD, and is not driven after HOLD.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it is 0 in the cycle before `mem_oe_n` falls.
- R7: After a read's OE-low cycles come one HOLD cycle and then TA_CYC cycles, all with strobes 1 and the bus undriven. Only after these does `req_ready` return to 1.
- R8: Let c(t) = max(1, ceil(t / clock period)). Then RD_CYC = max(c(OE access), c(address access) − 1, c(read cycle) − 2, 1). WR_CYC = max(c(WE pulse), c(data setup), c(CE to write end) − 1, c(address to write end) − 1). TA_CYC = c(output release). With these counts every RAM minimum is met.
- R9: `mem_addr` does not change while `mem_ce_n` stays 0 across consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | One-cycle read response pulse |
| rd_data | output | DATA_W | Read word, valid with rd_valid |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the RAM bus |

## Verification
The bench runs a clock at which every count exceeds one, so a design that loads its counters wrong visibly shortens or stretches OE-low and WE-low windows. It chains read-after-write to the same word, write-after-read, write-after-write, and requests held pending while busy. A missing turnaround would show up as drive starting too early, or as contention with the RAM model. Sampling the data one edge early returns stale or floating data. Request fields are scrambled as soon as each request is accepted, which exposes a controller that tracks its inputs instead of the captured copy. A behavioural RAM model measures WE pulse length, capture time after CE and OE fall, and the gap from OE rising to renewed drive.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TURN   = 3'd4
  } acc_state_e;

  // Cycles needed to cover t_ps, rounded up, never less than one.
  function automatic int unsigned cyc_up(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned sat_dec(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_req_reg.sv
`timescale 1ns/1ps
module asram_req_reg #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              write_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      write_q <= write_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  // R2: captured fields only move on an accepted request
  a_r2_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(write_q)));

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned TA_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic lat_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WR_CYC), TA_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  acc_state_e       state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wr_cur;
  logic             cnt_done;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign wr_cur    = req_ready ? req_write : lat_write;
  assign cnt_done  = (cnt == '0);
  assign capture   = (state == ST_STROBE) && !lat_write && cnt_done;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) nxt = ST_SETUP;
      end
      ST_SETUP: begin
        nxt     = ST_STROBE;
        cnt_nxt = lat_write ? WR_LOAD : RD_LOAD;
      end
      ST_STROBE: begin
        if (cnt_done) nxt = ST_HOLD;
        else          cnt_nxt = cnt - 1'b1;
      end
      ST_HOLD: begin
        if (lat_write) begin
          nxt = ST_IDLE;
        end else begin
          nxt     = ST_TURN;
          cnt_nxt = TA_LOAD;
        end
      end
      ST_TURN: begin
        if (cnt_done) nxt = ST_IDLE;
        else          cnt_nxt = cnt - 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the pins never glitch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      ce_n  <= !((nxt == ST_SETUP) || (nxt == ST_STROBE));
      oe_n  <= !((nxt == ST_STROBE) && !wr_cur);
      we_n  <= !((nxt == ST_STROBE) && wr_cur);
      dq_oe <= wr_cur && ((nxt == ST_SETUP) || (nxt == ST_STROBE) || (nxt == ST_HOLD));
    end
  end

  a_r6_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && dq_oe));

  a_r6_drive_off_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe));

  a_r5_we_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  a_r3_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  a_r2_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n));

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (ce_n && oe_n && we_n && !dq_oe));

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!capture) |-> $stable(rd_data));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W          = 15,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned CLK_PERIOD_PS   = 10000,
  parameter int unsigned T_CYCLE_PS      = 10000,
  parameter int unsigned T_ACCESS_PS     = 10000,
  parameter int unsigned T_OE_ACCESS_PS  = 5000,
  parameter int unsigned T_WE_PULSE_PS   = 7000,
  parameter int unsigned T_CE_WRITE_PS   = 8000,
  parameter int unsigned T_ADDR_WRITE_PS = 7000,
  parameter int unsigned T_DATA_SETUP_PS = 5000,
  parameter int unsigned T_RELEASE_PS    = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // R8: strobe lengths in cycles, rounded up from the RAM minimums.
  // SETUP already holds CE low for one cycle and HOLD adds one to the cycle time.
  localparam int unsigned RD_CYC = umax(
      umax(cyc_up(T_OE_ACCESS_PS, CLK_PERIOD_PS), sat_dec(cyc_up(T_ACCESS_PS, CLK_PERIOD_PS), 1)),
      umax(sat_dec(cyc_up(T_CYCLE_PS, CLK_PERIOD_PS), 2), 1));
  localparam int unsigned WR_CYC = umax(
      umax(cyc_up(T_WE_PULSE_PS, CLK_PERIOD_PS), cyc_up(T_DATA_SETUP_PS, CLK_PERIOD_PS)),
      umax(sat_dec(cyc_up(T_CE_WRITE_PS, CLK_PERIOD_PS), 1),
           sat_dec(cyc_up(T_ADDR_WRITE_PS, CLK_PERIOD_PS), 1)));
  localparam int unsigned TA_CYC = cyc_up(T_RELEASE_PS, CLK_PERIOD_PS);

  logic accept;
  logic capture;
  logic lat_write;

  asram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .write_in (req_write),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .write_q  (lat_write),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out)
  );

  asram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .lat_write (lat_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  asram_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r5_data_stable_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int  CLK_NS = 4;
  localparam int  P_PS   = CLK_NS * 1000;
  localparam int  NREQ   = 12;
  localparam int  WD_LIM = 4000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_write;
  logic [7:0] req_addr, req_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] mem_addr, mem_dq_out, mem_dq_in;
  logic       mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  int checks = 0;
  int failures = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  asram_ctrl #(.ADDR_W(8), .DATA_W(8), .CLK_PERIOD_PS(P_PS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // R8 counts from the requirement formula
  function automatic int cu(input int t_ps);
    int c;
    c = (t_ps + P_PS - 1) / P_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int RD_N = 2;
  localparam int WR_N = 2;
  localparam int TA_N = 2;
  int rd_n, wr_n, ta_n;

  // ---------------- behavioural RAM ----------------
  logic [7:0] ram [256];
  logic [7:0] ref_mem [256];
  logic       ram_drive;
  int         wr_len = 0;
  logic [7:0] wr_addr_s, wr_data_s;
  realtime    t_ce_fall = 0.0, t_oe_fall = 0.0, t_oe_rise = -100.0;

  assign ram_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = mem_dq_oe ? mem_dq_out : (ram_drive ? ram[mem_addr] : 8'h00);

  always @(negedge mem_ce_n) t_ce_fall = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_oe_n) t_oe_rise = $realtime;

  always @(posedge mem_dq_oe) begin
    checks++;
    if ($realtime - t_oe_rise < 7.0) begin
      failures++;
      $display("FAIL R7 drive %0.1f ns after OE release, expected >= 7.0", $realtime - t_oe_rise);
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (mem_dq_oe && ram_drive) begin
      failures++;
      $display("FAIL R6 bus contention: dq_oe=%b ram_drive=%b expected no overlap", mem_dq_oe, ram_drive);
    end
    if (!mem_we_n && !mem_ce_n) begin
      wr_len++;
      wr_addr_s = mem_addr;
      wr_data_s = mem_dq_out;
    end else if (wr_len > 0) begin
      checks++;
      if (wr_len * CLK_NS < 7) begin
        failures++;
        $display("FAIL R8 WE pulse %0d ns expected >= 7", wr_len * CLK_NS);
      end
      checks++;
      if (!mem_dq_oe || mem_dq_out !== wr_data_s) begin
        failures++;
        $display("FAIL R5 data hold after write end: oe=%b data=%h expected oe=1 data=%h",
                 mem_dq_oe, mem_dq_out, wr_data_s);
      end
      ram[wr_addr_s] = wr_data_s;
      wr_len = 0;
    end
  end

  // ---------------- reference model ----------------
  typedef struct packed {
    logic       ready;
    logic       ce_n, oe_n, we_n, drv, rdv;
    logic [7:0] rdat;
    logic [7:0] addr;
    logic [7:0] wdat;
    logic       chk_addr;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  exp_t e;

  function automatic exp_t mk(input logic rdy, input logic ce, input logic oe, input logic we,
                              input logic drv, input logic rdv, input logic [7:0] rdat,
                              input logic [7:0] a, input logic [7:0] wd, input logic ca,
                              input logic [7:0] tg);
    exp_t x;
    x.ready = rdy; x.ce_n = ce; x.oe_n = oe; x.we_n = we; x.drv = drv; x.rdv = rdv;
    x.rdat = rdat; x.addr = a; x.wdat = wd; x.chk_addr = ca; x.tag = tg;
    return x;
  endfunction

  task automatic push_access(input logic wr, input logic [7:0] a, input logic [7:0] d);
    if (wr) begin
      q.push_back(mk(0, 0, 1, 1, 1, 0, 8'h00, a, d, 1, 8'd5));
      for (int i = 0; i < wr_n; i++) q.push_back(mk(0, 0, 1, 0, 1, 0, 8'h00, a, d, 1, 8'd5));
      q.push_back(mk(0, 1, 1, 1, 1, 0, 8'h00, a, d, 1, 8'd5));
      ref_mem[a] = d;
    end else begin
      q.push_back(mk(0, 0, 1, 1, 0, 0, 8'h00, a, 8'h00, 1, 8'd3));
      for (int i = 0; i < rd_n; i++) q.push_back(mk(0, 0, 0, 1, 0, 0, 8'h00, a, 8'h00, 1, 8'd3));
      q.push_back(mk(0, 1, 1, 1, 0, 1, ref_mem[a], a, 8'h00, 1, 8'd4));
      for (int i = 0; i < ta_n; i++) q.push_back(mk(0, 1, 1, 1, 0, 0, 8'h00, a, 8'h00, 0, 8'd7));
    end
  endtask

  task automatic compare(input exp_t x, input int cyc);
    logic [4:0] got, want;
    got  = {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
    want = {x.ready, x.ce_n, x.oe_n, x.we_n, x.drv};
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL R%0d cycle %0d rdy/ce/oe/we/drv got %b expected %b", x.tag, cyc, got, want);
    end
    checks++;
    if (rd_valid !== x.rdv || (x.rdv && rd_data !== x.rdat)) begin
      failures++;
      $display("FAIL R4 cycle %0d rd_valid/data got %b/%h expected %b/%h",
               cyc, rd_valid, rd_data, x.rdv, x.rdat);
    end
    if (x.rdv) begin
      checks++;
      if (($realtime - CLK_NS / 2.0) - t_ce_fall < 10.0 ||
          ($realtime - CLK_NS / 2.0) - t_oe_fall < 5.0) begin
        failures++;
        $display("FAIL R8 capture too early: after CE %0.1f ns after OE %0.1f ns expected >= 10.0 / 5.0",
                 ($realtime - CLK_NS / 2.0) - t_ce_fall, ($realtime - CLK_NS / 2.0) - t_oe_fall);
      end
    end
    if (x.chk_addr) begin
      checks++;
      if (mem_addr !== x.addr) begin
        failures++;
        $display("FAIL R9 cycle %0d address got %h expected %h (R2 capture)", cyc, mem_addr, x.addr);
      end
    end
    if (x.drv) begin
      checks++;
      if (mem_dq_out !== x.wdat) begin
        failures++;
        $display("FAIL R5 cycle %0d write data got %h expected %h", cyc, mem_dq_out, x.wdat);
      end
    end
  endtask

  // ---------------- stimulus ----------------
  logic       rq_wr  [NREQ];
  logic [7:0] rq_a   [NREQ];
  logic [7:0] rq_d   [NREQ];
  int         rq_gap [NREQ];

  task automatic set_rq(input int i, input logic w, input logic [7:0] a, input logic [7:0] d, input int g);
    rq_wr[i] = w; rq_a[i] = a; rq_d[i] = d; rq_gap[i] = g;
  endtask

  initial begin
    int k, gap, cyc, tail;
    bit done;
    exp_t idle_e;

    rd_n = mx(mx(cu(5000), cu(10000) - 1), mx(cu(10000) - 2, 1));
    wr_n = mx(mx(cu(7000), cu(5000)), mx(cu(8000) - 1, cu(7000) - 1));
    ta_n = cu(7000);
    checks++;
    if (rd_n != RD_N || wr_n != WR_N || ta_n != TA_N) begin
      failures++;
      $display("FAIL R8 counts got %0d/%0d/%0d expected %0d/%0d/%0d", rd_n, wr_n, ta_n, RD_N, WR_N, TA_N);
    end

    for (int i = 0; i < 256; i++) begin
      ram[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    set_rq(0,  0, 8'h00, 8'h00, 2);
    set_rq(1,  0, 8'hFF, 8'h00, 0);
    set_rq(2,  1, 8'h10, 8'hA5, 0);
    set_rq(3,  0, 8'h10, 8'h00, 0);
    set_rq(4,  1, 8'hFF, 8'h00, 3);
    set_rq(5,  1, 8'h00, 8'hFF, 0);
    set_rq(6,  0, 8'hFF, 8'h00, 0);
    set_rq(7,  0, 8'h00, 8'h00, 1);
    set_rq(8,  1, 8'h33, 8'h3C, 0);
    set_rq(9,  1, 8'h33, 8'hC3, 2);
    set_rq(10, 0, 8'h33, 8'h00, 0);
    set_rq(11, 0, 8'h7E, 8'h00, 0);

    idle_e = mk(1, 1, 1, 1, 0, 0, 8'h00, 8'h00, 8'h00, 0, 8'd2);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = 8'h00; req_wdata = 8'h00;

    // R1: quiet pins throughout reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if ({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid} !== 5'b11100) begin
        failures++;
        $display("FAIL R1 reset pins ce/oe/we/drv/rdv got %b expected 11100",
                 {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid});
      end
    end
    rst_n = 1'b1;

    k = 0; gap = rq_gap[0]; cyc = 0; tail = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (q.size() > 0) e = q.pop_front();
      else              e = idle_e;
      compare(e, cyc);
      if (k < NREQ) begin
        if (gap > 0) begin
          gap--;
          req_valid = 1'b0;
          req_write = ~req_write;
          req_addr  = 8'(8'hE1 ^ cyc);
          req_wdata = 8'h99;
        end else begin
          req_valid = 1'b1;
          req_write = rq_wr[k];
          req_addr  = rq_a[k];
          req_wdata = rq_d[k];
          if (e.ready) begin
            push_access(rq_wr[k], rq_a[k], rq_d[k]);
            k++;
            if (k < NREQ) gap = rq_gap[k];
          end
        end
      end else begin
        // R2: scrambled fields after the last acceptance must not matter
        req_valid = 1'b0;
        req_write = ~req_write;
        req_addr  = 8'(8'h5B ^ cyc);
        req_wdata = 8'h66;
        if (q.size() == 0) tail++;
        if (tail > 3) done = 1;
      end
      if (cyc > WD_LIM) begin
        failures++;
        $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
        done = 1;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule